// File: doc/BRIEF.md
# Branch-to-Predicate Compare Unit

This block gives conditional-branch encodings a second meaning. When a branch instruction names at least one source register that is configured as a vector, the unit does not produce a branch. It compares the two sources element by element and writes the outcomes as bits of a predicate register. The predicate register number is taken from bits 11:7 of the instruction, the field a branch would use for its low offset bits. Bits 31:25 are reserved and ignored. When neither source is a vector, the instruction is flagged as an ordinary branch and no predicate state changes.

A second write port supports floating-point-style compares. Such a compare updates a single bit of a predicate register: the bit at the current element index. The unit also holds the predicate registers that later element operations use as masks. It produces per-element enables, and it merges new and old element results so that an element that is masked off keeps its previous value and is not zeroed.

Top module: `brp_unit`

## Requirements
- R1: After reset every predicate register is all zeros. `pred_wr_valid`, `pred_wr_reg`, `pred_word`, `br_pass` and `illegal` are zero.
- R2: An instruction acts only when `op_valid` is high and bits 6:0 equal 1100011. Any other opcode changes no predicate bit and raises no outcome flag.
- R3: A branch is vectorised when the register named by bits 19:15, or the one named by bits 24:20, is nonzero and has its bit set in `vec_flags`. A branch that is not vectorised raises `br_pass` for one cycle, one cycle later, and writes nothing.
- R4: The compare kind comes from bits 14:12:
  - 000 means equal.
  - 001 means not equal.
  - 100 means signed less-than.
  - 101 means signed greater-or-equal.

  For a legal vectorised branch, bit i of the predicate register named by bits 11:7 is set to 1 when the condition holds for element i of source 1 against element i of source 2, and to 0 otherwise. One cycle later `pred_wr_valid` pulses and `pred_wr_reg` holds that register number.
- R5: When bits 24:20 are zero, source 2 is zero for every element whatever `op_src2` carries. This covers the compressed compare-with-zero forms after expansion.
- R6: Predicate bits at index `vec_len` or above are left unchanged by a compare write. A `vec_len` larger than the element count covers all elements.
- R7: A vectorised branch with any other bits 14:12 value raises `illegal` one cycle later and writes nothing.
- R8: A single-bit compare write (`fc_valid`) sets bit `fc_idx` of register `fc_reg` to `fc_bit` and touches no other bit. It is ignored when `fc_idx` is at or above `vec_len`. When it targets the same register in the same cycle as a branch compare write, its bit overrides the branch result.
- R9: `elem_en[i]` is high when i is below `vec_len` and either `mask_en` is low or bit i of the predicate register `mask_reg` is 1. It reflects the stored state combinationally.
- R10: Element i of `res_out` equals element i of `res_new` when `elem_en[i]` is high, and element i of `res_old` otherwise.
- R11: At most one of `pred_wr_valid`, `br_pass` and `illegal` is high in any cycle. `pred_word` always shows the stored contents of the register named by `pred_wr_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_insn | input | 32 | Decoded 32-bit instruction word |
| op_src1 | input | LANES*XLEN | Element values of source 1, element i at bits i*XLEN |
| op_src2 | input | LANES*XLEN | Element values of source 2 |
| vec_len | input | VLW | Active vector length |
| vec_flags | input | NREGS | Per-register vector flag |
| fc_valid | input | 1 | Single-bit compare result present |
| fc_reg | input | RW | Predicate register for the single-bit write |
| fc_idx | input | IDXW | Element index for the single-bit write |
| fc_bit | input | 1 | Compare outcome to store |
| mask_en | input | 1 | Apply predicate masking to element enables |
| mask_reg | input | RW | Predicate register used as mask |
| res_new | input | LANES*XLEN | Newly computed element results |
| res_old | input | LANES*XLEN | Previous destination element values |
| res_out | output | LANES*XLEN | Merged element results |
| elem_en | output | LANES | Per-element execute enables |
| pred_wr_valid | output | 1 | A predicate compare write completed |
| pred_wr_reg | output | RW | Register of the latest compare write |
| pred_word | output | LANES | Stored contents of `pred_wr_reg` |
| br_pass | output | 1 | Instruction handled as an ordinary branch |
| illegal | output | 1 | Vectorised branch with an unknown compare kind |

## Verification
The outcome flags, `pred_wr_reg` and `pred_word` are registered. They are due one cycle after the rising edge that captured the instruction, so the bench samples them at the falling edge that follows that edge. `elem_en` and `res_out` are combinational from the stored predicate registers and the present inputs. They are checked before the capturing edge, against the model state as it stood before that edge. A predicate write therefore first shows in `elem_en` in the cycle after it. The behavioural model updates its predicate array at each rising edge from the same inputs, and it is compared on every clock.

// File: rtl/brp_pkg.sv
package brp_pkg;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   typedef enum logic [2:0] {
      CMP_EQ = 3'b000,
      CMP_NE = 3'b001,
      CMP_LT = 3'b100,
      CMP_GE = 3'b101
   } cmp_kind_e;

   typedef struct packed {
      logic      is_branch;
      logic      vec;
      logic      legal;
      cmp_kind_e kind;
      logic [4:0] rs1;
      logic [4:0] rs2;
      logic [4:0] pd;
   } dec_s;

endpackage

// File: rtl/brp_decode.sv
module brp_decode
   import brp_pkg::*;
#(
   parameter int NREGS = 32
) (
   input  logic [31:0]      insn,
   input  logic [NREGS-1:0] vec_flags,
   output dec_s             dec
);
   localparam int RW = $clog2(NREGS);

   generate
      if (NREGS != 32) begin : g_bad_nregs
         $error("brp_decode: NREGS must be 32 to match 5-bit register fields");
      end
   endgenerate

   logic [2:0] f3;
   logic       unused_rsv;
   logic       rs1_vec, rs2_vec;

   // reserved field 31:25 carries no meaning in the converted form
   assign unused_rsv = ^insn[31:25];
   assign f3         = insn[14:12];

   assign rs1_vec = (insn[19:15] != '0) && vec_flags[insn[15 +: RW]];
   assign rs2_vec = (insn[24:20] != '0) && vec_flags[insn[20 +: RW]];

   always_comb begin
      dec.is_branch = (insn[6:0] == OPC_BRANCH);
      dec.vec       = rs1_vec || rs2_vec;
      dec.legal     = (f3 == CMP_EQ) || (f3 == CMP_NE) ||
                      (f3 == CMP_LT) || (f3 == CMP_GE);
      dec.kind      = cmp_kind_e'(f3);
      dec.rs1       = insn[19:15];
      dec.rs2       = insn[24:20];
      dec.pd        = insn[11:7];
   end

endmodule

// File: rtl/brp_lane_cmp.sv
module brp_lane_cmp
   import brp_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int STYLE = 1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  cmp_kind_e       kind,
   output logic            hit
);
   logic eq, lt;

   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("brp_lane_cmp: XLEN must be at least 2");
      end
      if (STYLE == 0) begin : g_rel
         assign eq = (a == b);
         assign lt = ($signed(a) < $signed(b));
      end else begin : g_sub
         logic [XLEN:0] diff;
         assign diff = {a[XLEN-1], a} - {b[XLEN-1], b};
         assign eq   = (diff == '0);
         assign lt   = diff[XLEN];
      end
   endgenerate

   always_comb begin
      unique case (kind)
         CMP_EQ:  hit = eq;
         CMP_NE:  hit = !eq;
         CMP_LT:  hit = lt;
         CMP_GE:  hit = !lt;
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/brp_pred_file.sv
module brp_pred_file #(
   parameter int LANES = 8,
   parameter int NREGS = 32,
   parameter int VLW   = 4,
   parameter int IDXW  = 3,
   parameter int RW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RW-1:0]    wr_reg,
   input  logic [LANES-1:0] wr_bits,
   input  logic [VLW-1:0]   vlen,
   input  logic             f_en,
   input  logic [RW-1:0]    f_reg,
   input  logic [IDXW-1:0]  f_idx,
   input  logic             f_bit,
   input  logic             mask_en,
   input  logic [RW-1:0]    mask_reg,
   input  logic [RW-1:0]    rd_reg,
   output logic [LANES-1:0] elem_en,
   output logic [LANES-1:0] rd_word
);
   logic [LANES-1:0] q   [NREGS];
   logic [LANES-1:0] nxt [NREGS];
   logic [LANES-1:0] lm;
   logic [LANES-1:0] mask_bits;
   logic             f_ok;

   generate
      if ((1 << RW) != NREGS) begin : g_bad_rw
         $error("brp_pred_file: NREGS must equal 2**RW");
      end
   endgenerate

   // elements below the vector length
   always_comb begin
      for (int i = 0; i < LANES; i++) lm[i] = (i < int'(vlen));
   end

   assign f_ok = f_en && (int'(f_idx) < int'(vlen)) && (int'(f_idx) < LANES);

   always_comb begin
      for (int r = 0; r < NREGS; r++) begin
         nxt[r] = q[r];
         if (wr_en && (wr_reg == RW'(r)))
            nxt[r] = (q[r] & ~lm) | (wr_bits & lm);
         if (f_ok && (f_reg == RW'(r)))
            nxt[r][f_idx] = f_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGS; r++) q[r] <= '0;
      end else begin
         for (int r = 0; r < NREGS; r++) q[r] <= nxt[r];
      end
   end

   assign mask_bits = mask_en ? q[mask_reg] : '1;
   assign elem_en   = lm & mask_bits;
   assign rd_word   = q[rd_reg];

   AST_TAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !f_en) |=> (((q[$past(wr_reg)] ^ $past(q[wr_reg])) & ~$past(lm)) == '0)); // R6

   AST_FCMP_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (f_en && !wr_en) |=> ($countones(q[$past(f_reg)] ^ $past(q[f_reg])) <= 1)); // R8

endmodule

// File: rtl/brp_unit.sv
module brp_unit
   import brp_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int LANES     = 8,
   parameter int NREGS     = 32,
   parameter int CMP_STYLE = 1,
   localparam int VLW      = $clog2(LANES + 1),
   localparam int IDXW     = $clog2(LANES),
   localparam int RW       = $clog2(NREGS),
   localparam int BUSW     = LANES * XLEN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [31:0]      op_insn,
   input  logic [BUSW-1:0]  op_src1,
   input  logic [BUSW-1:0]  op_src2,
   input  logic [VLW-1:0]   vec_len,
   input  logic [NREGS-1:0] vec_flags,
   input  logic             fc_valid,
   input  logic [RW-1:0]    fc_reg,
   input  logic [IDXW-1:0]  fc_idx,
   input  logic             fc_bit,
   input  logic             mask_en,
   input  logic [RW-1:0]    mask_reg,
   input  logic [BUSW-1:0]  res_new,
   input  logic [BUSW-1:0]  res_old,
   output logic [BUSW-1:0]  res_out,
   output logic [LANES-1:0] elem_en,
   output logic             pred_wr_valid,
   output logic [RW-1:0]    pred_wr_reg,
   output logic [LANES-1:0] pred_word,
   output logic             br_pass,
   output logic             illegal
);
   generate
      if (LANES < 2 || LANES > XLEN) begin : g_bad_lanes
         $error("brp_unit: LANES must be within 2..XLEN");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
         $error("brp_unit: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   dec_s             dec;
   logic [LANES-1:0] hits;
   logic             act, wr_en;

   brp_decode #(.NREGS(NREGS)) u_dec (
      .insn      (op_insn),
      .vec_flags (vec_flags),
      .dec       (dec)
   );

   assign act   = op_valid && dec.is_branch;
   assign wr_en = act && dec.vec && dec.legal;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [XLEN-1:0] b_val;
         // register 0 reads as zero: compressed compare-with-zero forms
         assign b_val = (dec.rs2 == '0) ? '0 : op_src2[i*XLEN +: XLEN];

         brp_lane_cmp #(.XLEN(XLEN), .STYLE(CMP_STYLE)) u_cmp (
            .a    (op_src1[i*XLEN +: XLEN]),
            .b    (b_val),
            .kind (dec.kind),
            .hit  (hits[i])
         );

         assign res_out[i*XLEN +: XLEN] = elem_en[i] ? res_new[i*XLEN +: XLEN]
                                                     : res_old[i*XLEN +: XLEN];

         AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !elem_en[i] |-> (res_out[i*XLEN +: XLEN] == res_old[i*XLEN +: XLEN])); // R10
      end
   endgenerate

   brp_pred_file #(
      .LANES (LANES), .NREGS (NREGS), .VLW (VLW), .IDXW (IDXW), .RW (RW)
   ) u_pf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_reg   (dec.pd),
      .wr_bits  (hits),
      .vlen     (vec_len),
      .f_en     (fc_valid),
      .f_reg    (fc_reg),
      .f_idx    (fc_idx),
      .f_bit    (fc_bit),
      .mask_en  (mask_en),
      .mask_reg (mask_reg),
      .rd_reg   (pred_wr_reg),
      .elem_en  (elem_en),
      .rd_word  (pred_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_wr_valid <= 1'b0;
         pred_wr_reg   <= '0;
         br_pass       <= 1'b0;
         illegal       <= 1'b0;
      end else begin
         pred_wr_valid <= wr_en;
         br_pass       <= act && !dec.vec;
         illegal       <= act && dec.vec && !dec.legal;
         if (wr_en) pred_wr_reg <= dec.pd;
      end
   end

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pred_wr_valid, br_pass, illegal})); // R11

   AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_insn[6:0] != OPC_BRANCH) |=> (!pred_wr_valid && !br_pass && !illegal)); // R2

   AST_EN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(vec_len) < LANES) |-> ((elem_en >> vec_len) == '0)); // R9

endmodule

// File: tb/tb_brp_unit.sv
module tb_brp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN  = 32;
   localparam int LANES = 8;
   localparam int BUSW  = XLEN * LANES;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [31:0]     op_insn = '0;
   logic [BUSW-1:0] op_src1 = '0, op_src2 = '0;
   logic [3:0]      vec_len = '0;
   logic [31:0]     vec_flags = '0;
   logic            fc_valid = 1'b0;
   logic [4:0]      fc_reg = '0;
   logic [2:0]      fc_idx = '0;
   logic            fc_bit = 1'b0;
   logic            mask_en = 1'b0;
   logic [4:0]      mask_reg = '0;
   logic [BUSW-1:0] res_new = '0, res_old = '0;
   logic [BUSW-1:0] res_out;
   logic [7:0]      elem_en;
   logic            pred_wr_valid, br_pass, illegal;
   logic [4:0]      pred_wr_reg;
   logic [7:0]      pred_word;

   brp_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_insn(op_insn),
      .op_src1(op_src1), .op_src2(op_src2), .vec_len(vec_len), .vec_flags(vec_flags),
      .fc_valid(fc_valid), .fc_reg(fc_reg), .fc_idx(fc_idx), .fc_bit(fc_bit),
      .mask_en(mask_en), .mask_reg(mask_reg), .res_new(res_new), .res_old(res_old),
      .res_out(res_out), .elem_en(elem_en), .pred_wr_valid(pred_wr_valid),
      .pred_wr_reg(pred_wr_reg), .pred_word(pred_word), .br_pass(br_pass), .illegal(illegal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [7:0] m_pred [32];
   logic       m_wv, m_pass, m_ill;
   logic [4:0] m_wreg;

   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [4:0] rs2, rs1, input logic [2:0] f3,
                                      input logic [4:0] pd, input logic [6:0] opc);
      return {7'b1010101, rs2, rs1, f3, pd, opc};
   endfunction

   function automatic bit cond(input logic [2:0] f3, input logic [31:0] a, b);
      case (f3)
         3'b000:  return a == b;
         3'b001:  return a != b;
         3'b100:  return $signed(a) < $signed(b);
         default: return $signed(a) >= $signed(b);
      endcase
   endfunction

   task automatic model_reset();
      for (int r = 0; r < 32; r++) m_pred[r] = '0;
      m_wv = 0; m_pass = 0; m_ill = 0; m_wreg = '0;
   endtask

   // one clock: combinational checks, model update at the edge, registered checks after
   task automatic tick();
      logic [7:0] exp_en;
      logic [BUSW-1:0] exp_res;
      bit br, vect, legal;
      logic [4:0] rs1, rs2, pd;
      logic [2:0] f3;
      #1;
      for (int i = 0; i < LANES; i++) begin
         exp_en[i] = (i < int'(vec_len)) && (!mask_en || m_pred[mask_reg][i]);
         exp_res[i*XLEN +: XLEN] = exp_en[i] ? res_new[i*XLEN +: XLEN] : res_old[i*XLEN +: XLEN];
      end
      chk(elem_en == exp_en, "R9 element enables", 256'(elem_en), 256'(exp_en));
      chk(res_out == exp_res, "R10 merged results", res_out, exp_res);
      @(posedge clk);
      rs1 = op_insn[19:15]; rs2 = op_insn[24:20]; pd = op_insn[11:7]; f3 = op_insn[14:12];
      br    = op_valid && (op_insn[6:0] == 7'b1100011);
      vect  = (rs1 != 0 && vec_flags[rs1]) || (rs2 != 0 && vec_flags[rs2]);
      legal = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b100) || (f3 == 3'b101);
      m_wv = br && vect && legal;
      m_pass = br && !vect;
      m_ill = br && vect && !legal;
      if (m_wv) begin
         for (int i = 0; i < LANES; i++)
            if (i < int'(vec_len))
               m_pred[pd][i] = cond(f3, op_src1[i*XLEN +: XLEN],
                                    (rs2 == 0) ? 32'd0 : op_src2[i*XLEN +: XLEN]);
         m_wreg = pd;
      end
      if (fc_valid && int'(fc_idx) < int'(vec_len)) m_pred[fc_reg][fc_idx] = fc_bit;
      @(negedge clk);
      chk(pred_wr_valid == m_wv, "R4 write pulse", 256'(pred_wr_valid), 256'(m_wv));
      chk(pred_wr_reg == m_wreg, "R4 write register", 256'(pred_wr_reg), 256'(m_wreg));
      chk(pred_word == m_pred[m_wreg], "R6 predicate word", 256'(pred_word), 256'(m_pred[m_wreg]));
      chk(br_pass == m_pass, "R3 ordinary branch", 256'(br_pass), 256'(m_pass));
      chk(illegal == m_ill, "R7 illegal kind", 256'(illegal), 256'(m_ill));
      chk($onehot0({pred_wr_valid, br_pass, illegal}), "R11 exclusive flags",
          256'({pred_wr_valid, br_pass, illegal}), 256'(0));
   endtask

   task automatic idle();
      op_valid = 0; fc_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, no mask, full length
      vec_len = 8;
      chk(pred_word == 8'h00 && !pred_wr_valid && !br_pass && !illegal && pred_wr_reg == 0,
          "R1 reset outputs", 256'({pred_word, pred_wr_reg, pred_wr_valid, br_pass, illegal}), 256'(0));
      tick();

      // R3: scalar operands -> ordinary branch
      op_valid = 1; op_insn = mk(5'd4, 5'd3, 3'b000, 5'd5, 7'b1100011);
      tick();

      // R4: equal compare on a vector, alternating lanes
      vec_flags = 32'h8;
      for (int i = 0; i < LANES; i++) begin
         op_src1[i*XLEN +: XLEN] = i;
         op_src2[i*XLEN +: XLEN] = (i % 2 == 0) ? i : 100;
      end
      tick();

      // R4: signed less-than with negative lanes
      op_insn = mk(5'd4, 5'd3, 3'b100, 5'd6, 7'b1100011);
      for (int i = 0; i < LANES; i++) begin
         op_src1[i*XLEN +: XLEN] = -i;
         op_src2[i*XLEN +: XLEN] = 1;
      end
      tick();

      // R4: signed greater-or-equal, vector flag on source 2 only
      vec_flags = 32'h10;
      op_insn = mk(5'd4, 5'd3, 3'b101, 5'd7, 7'b1100011);
      for (int i = 0; i < LANES; i++) begin
         op_src1[i*XLEN +: XLEN] = i - 4;
         op_src2[i*XLEN +: XLEN] = 0;
      end
      tick();

      // R5: source 2 field zero reads as zero
      vec_flags = 32'h8;
      op_insn = mk(5'd0, 5'd3, 3'b001, 5'd8, 7'b1100011);
      for (int i = 0; i < LANES; i++) begin
         op_src1[i*XLEN +: XLEN] = i & 1;
         op_src2[i*XLEN +: XLEN] = 32'hDEAD0000 + i;
      end
      tick();

      // R6: short vector keeps upper bits of register 5
      vec_len = 3;
      op_insn = mk(5'd4, 5'd3, 3'b001, 5'd5, 7'b1100011);
      tick();

      // R7: unknown compare kind
      vec_len = 8;
      op_insn = mk(5'd4, 5'd3, 3'b010, 5'd5, 7'b1100011);
      tick();

      // R2: non-branch opcode does nothing
      op_insn = mk(5'd4, 5'd3, 3'b000, 5'd5, 7'b0110011);
      tick();

      // R8: single-bit write, then read back through the mask
      idle();
      fc_valid = 1; fc_reg = 5; fc_idx = 0; fc_bit = 0;
      tick();
      fc_valid = 0; mask_en = 1; mask_reg = 5;
      tick();
      // R8: index at or above the length is ignored
      vec_len = 3; fc_valid = 1; fc_reg = 5; fc_idx = 6; fc_bit = 0;
      tick();
      vec_len = 8; fc_valid = 0;
      tick();
      // R8: same-cycle write to one register, single bit wins
      op_valid = 1; op_insn = mk(5'd4, 5'd3, 3'b000, 5'd9, 7'b1100011);
      for (int i = 0; i < LANES; i++) begin
         op_src1[i*XLEN +: XLEN] = 7;
         op_src2[i*XLEN +: XLEN] = 7;
      end
      fc_valid = 1; fc_reg = 9; fc_idx = 2; fc_bit = 0;
      tick();
      // R9, R10: mask from register 9 applied to merge
      idle(); mask_reg = 9;
      for (int i = 0; i < LANES; i++) begin
         res_new[i*XLEN +: XLEN] = 32'h1000 + i;
         res_old[i*XLEN +: XLEN] = 32'h2000 + i;
      end
      tick();
      vec_len = 5;
      tick();

      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
         logic [6:0] opc;
         opc = ($urandom % 4 != 0) ? 7'b1100011 : 7'($urandom);
         op_valid  = ($urandom % 5 != 0);
         op_insn   = {7'($urandom), 5'($urandom % 6), 5'($urandom % 6),
                      3'($urandom), 5'($urandom % 12), opc};
         vec_flags = $urandom;
         vec_len   = 4'($urandom % 10);
         op_src1   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom} & {8{32'h8000_0003}};
         op_src2   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom} & {8{32'h8000_0003}};
         fc_valid  = ($urandom % 3 == 0);
         fc_reg    = 5'($urandom % 12);
         fc_idx    = 3'($urandom);
         fc_bit    = 1'($urandom);
         mask_en   = 1'($urandom);
         mask_reg  = 5'($urandom % 12);
         res_new   = {8{$urandom}};
         res_old   = {8{$urandom}};
         tick();
      end
      idle();
      tick();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule